// File: doc/BRIEF.md
# Dual-Clock FIFO with Flag-Resolved Pointers

This block carries data words from a producer clocked by one clock to a consumer clocked by an unrelated clock. Each side owns a pointer of exactly address width. The pointer leaves its domain as a registered Gray value and enters the other domain through a two-stage synchronizer. There is no extra wrap bit, so equal pointers can mean either "nothing stored" or "every slot used". A registered flag on each side settles which case holds. The read side's empty flag is set by the read that makes the pointers meet. The write side's full flag is set by the write that makes them meet. Each flag clears once the synchronized opposite pointer moves away.

The producer presents a word with a write enable and watches the full flag. The consumer raises a read enable while the empty flag is low, and the word arrives on a registered output one read clock later. Each domain has its own asynchronous active-low reset, which is released synchronously inside the block. A build parameter chooses how the pointers count. They can count in binary and convert to Gray, or count in Gray directly and address the storage with the Gray value.

Top module: `dual_clock_fifo`

## Requirements
- R1: After reset, the empty output is 1, the full output is 0 and the read data output is 0.
- R2: Words leave the read port in the order they were accepted at the write port, across any number of pointer wraps, for any mix of write and read rates.
- R3: Starting from empty with no reads, full stays 0 through the first DEPTH-1 accepted writes and is 1 right after the write clock edge that accepts the DEPTH-th word (DEPTH = 2^AW).
- R4: A write issued while full is 1 is dropped. The write pointer does not move and no stored word is overwritten.
- R5: The read clock edge that accepts the last stored word sets empty to 1, visible right after that edge.
- R6: A read issued while empty is 1 is dropped. The read pointer and the read data output stay unchanged.
- R7: After a write into an empty FIFO, empty returns to 0 no later than the third read clock edge after the accepting write edge.
- R8: After a read from a full FIFO, full returns to 0 no later than the third write clock edge after the accepting read edge.
- R9: Read data is registered. It takes the addressed word on the read clock edge that accepts a read and holds its value on every edge without an accepted read.
- R10: Each side's outgoing Gray pointer changes in at most one bit per clock and stays unchanged on any clock without an accepted access.
- R11: With the Gray-counting build option, where storage is indexed by the Gray pointer, the flags and read data match the binary-counting build cycle for cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| wr_rst_n | input | 1 | Write-side asynchronous active-low reset |
| wr_en | input | 1 | Write request; accepted when wr_full is 0 |
| wr_data | input | DW | Word to store |
| wr_full | output | 1 | Registered full flag, write domain |
| rd_clk | input | 1 | Read-side clock |
| rd_rst_n | input | 1 | Read-side asynchronous active-low reset |
| rd_en | input | 1 | Read request; accepted when rd_empty is 0 |
| rd_data | output | DW | Registered read word |
| rd_empty | output | 1 | Registered empty flag, read domain |

## Verification
A pointer that skips or repeats a slot shows up at the very next read as a word out of order against the reference queue, or as a duplicated word. A flag that is set wrongly shows within a few clocks. A missed clear stalls a stream, which the bounded post-write and post-read flag checks catch. A missed set lets a dropped access through, which breaks the word order at the following read. Running a second build with Gray-indexed storage next to the first exposes any step in which the two pointer styles differ, on the same read clock.

// File: rtl/dcfifo_pkg.sv
package dcfifo_pkg;
  typedef enum logic {
    PTR_BINARY = 1'b0,
    PTR_GRAY   = 1'b1
  } ptr_mode_e;
endpackage

// File: rtl/dcfifo_rst_sync.sv
module dcfifo_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);
  logic [1:0] stg_q;
  logic [1:0] stg_d;

  always_comb stg_d = {stg_q[0], 1'b1};

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stg_q <= 2'b00;
    else         stg_q <= stg_d;
  end

  assign rst_n = stg_q[1];
endmodule

// File: rtl/dcfifo_sync2.sv
module dcfifo_sync2 #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d;
      sync_q <= meta_q;
    end
  end

  assign q = sync_q;
endmodule

// File: rtl/dcfifo_ptr.sv
module dcfifo_ptr #(
  parameter int                    AW   = 3,
  parameter dcfifo_pkg::ptr_mode_e MODE = dcfifo_pkg::PTR_BINARY
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  output logic [AW-1:0] gray,
  output logic [AW-1:0] gray_nxt,
  output logic [AW-1:0] addr
);
  generate
    if (MODE == dcfifo_pkg::PTR_BINARY) begin : g_bin
      logic [AW-1:0] bin_q, bin_d, gray_q, gray_d;

      always_comb begin
        bin_d  = bin_q + AW'(1);
        gray_d = bin_d ^ (bin_d >> 1);
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          bin_q  <= '0;
          gray_q <= '0;
        end else if (adv) begin
          bin_q  <= bin_d;
          gray_q <= gray_d;
        end
      end

      assign gray     = gray_q;
      assign gray_nxt = gray_d;
      assign addr     = bin_q;
    end else begin : g_gray
      logic [AW-1:0] gray_q, bin_cur, bin_d, gray_d;

      always_comb begin
        for (int i = 0; i < AW; i++) bin_cur[i] = ^(gray_q >> i);
        bin_d  = bin_cur + AW'(1);
        gray_d = bin_d ^ (bin_d >> 1);
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   gray_q <= '0;
        else if (adv) gray_q <= gray_d;
      end

      assign gray     = gray_q;
      assign gray_nxt = gray_d;
      assign addr     = gray_q;
    end
  endgenerate

  // R10: outgoing pointer moves by at most one bit per clock
  a_r10_gray_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(gray ^ $past(gray)) <= 1);

  // R10: no accepted access, no pointer movement
  a_r10_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(gray));
endmodule

// File: rtl/dcfifo_side.sv
module dcfifo_side #(
  parameter int                    AW       = 3,
  parameter dcfifo_pkg::ptr_mode_e MODE     = dcfifo_pkg::PTR_BINARY,
  parameter bit                    RST_FLAG = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic [AW-1:0] far_gray,
  output logic          flag,
  output logic          acc,
  output logic [AW-1:0] addr,
  output logic [AW-1:0] gray
);
  logic [AW-1:0] gray_nxt;
  logic          flag_q, flag_d;

  assign acc = req & ~flag_q;

  dcfifo_ptr #(.AW(AW), .MODE(MODE)) u_ptr (
    .clk      (clk),
    .rst_n    (rst_n),
    .adv      (acc),
    .gray     (gray),
    .gray_nxt (gray_nxt),
    .addr     (addr)
  );

  always_comb begin
    flag_d = flag_q;
    if (acc && (gray_nxt == far_gray))     flag_d = 1'b1;
    else if (flag_q && (far_gray != gray)) flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= RST_FLAG;
    else        flag_q <= flag_d;
  end

  assign flag = flag_q;

  // R4 (write side) and R6 (read side): a raised flag freezes the pointer
  a_r4_r6_stall_when_flagged: assert property (@(posedge clk) disable iff (!rst_n)
    flag |=> $stable(gray));

  // R3 (write side) and R5 (read side): a raised flag means the pointers meet
  a_r3_r5_flag_at_meet: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && $stable(far_gray)) |-> (gray == far_gray));
endmodule

// File: rtl/dcfifo_mem.sv
module dcfifo_mem #(
  parameter int AW = 3,
  parameter int DW = 16
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          rclk,
  input  logic          rrst_n,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] store_q [DEPTH];
  logic [DW-1:0] rdata_q;

  always_ff @(posedge wclk) begin
    if (we) store_q[waddr] <= wdata;
  end

  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n)  rdata_q <= '0;
    else if (re)  rdata_q <= store_q[raddr];
  end

  assign rdata = rdata_q;

  // R9: output word only changes on an accepted read
  a_r9_rdata_hold: assert property (@(posedge rclk) disable iff (!rrst_n)
    !re |=> $stable(rdata));
endmodule

// File: rtl/dual_clock_fifo.sv
module dual_clock_fifo #(
  parameter int                    DW   = 16,
  parameter int                    AW   = 3,
  parameter dcfifo_pkg::ptr_mode_e MODE = dcfifo_pkg::PTR_BINARY
) (
  input  logic          wr_clk,
  input  logic          wr_rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  output logic          wr_full,
  input  logic          rd_clk,
  input  logic          rd_rst_n,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  output logic          rd_empty
);
  logic          wr_rst_s, rd_rst_s;
  logic          wr_acc, rd_acc;
  logic [AW-1:0] wr_gray, rd_gray, wr_gray_in_rd, rd_gray_in_wr;
  logic [AW-1:0] wr_addr, rd_addr;

  dcfifo_rst_sync u_wr_rst (.clk(wr_clk), .arst_n(wr_rst_n), .rst_n(wr_rst_s));
  dcfifo_rst_sync u_rd_rst (.clk(rd_clk), .arst_n(rd_rst_n), .rst_n(rd_rst_s));

  dcfifo_sync2 #(.W(AW)) u_rd2wr (
    .clk(wr_clk), .rst_n(wr_rst_s), .d(rd_gray), .q(rd_gray_in_wr)
  );
  dcfifo_sync2 #(.W(AW)) u_wr2rd (
    .clk(rd_clk), .rst_n(rd_rst_s), .d(wr_gray), .q(wr_gray_in_rd)
  );

  dcfifo_side #(.AW(AW), .MODE(MODE), .RST_FLAG(1'b0)) u_wr_side (
    .clk      (wr_clk),
    .rst_n    (wr_rst_s),
    .req      (wr_en),
    .far_gray (rd_gray_in_wr),
    .flag     (wr_full),
    .acc      (wr_acc),
    .addr     (wr_addr),
    .gray     (wr_gray)
  );

  dcfifo_side #(.AW(AW), .MODE(MODE), .RST_FLAG(1'b1)) u_rd_side (
    .clk      (rd_clk),
    .rst_n    (rd_rst_s),
    .req      (rd_en),
    .far_gray (wr_gray_in_rd),
    .flag     (rd_empty),
    .acc      (rd_acc),
    .addr     (rd_addr),
    .gray     (rd_gray)
  );

  dcfifo_mem #(.AW(AW), .DW(DW)) u_mem (
    .wclk   (wr_clk),
    .we     (wr_acc),
    .waddr  (wr_addr),
    .wdata  (wr_data),
    .rclk   (rd_clk),
    .rrst_n (rd_rst_s),
    .re     (rd_acc),
    .raddr  (rd_addr),
    .rdata  (rd_data)
  );
endmodule

// File: tb/test_dual_clock_fifo.sv
`timescale 1ns/1ps
module test_dual_clock_fifo;
  localparam int DW    = 16;
  localparam int AW    = 3;
  localparam int DEPTH = 1 << AW;

  logic wr_clk = 1'b0;
  logic rd_clk = 1'b0;
  always #2   wr_clk = ~wr_clk;
  always #3.5 rd_clk = ~rd_clk;

  logic          wr_rst_n, rd_rst_n, wr_en, rd_en;
  logic [DW-1:0] wr_data;
  logic          wr_full, rd_empty, wr_full_g, rd_empty_g;
  logic [DW-1:0] rd_data, rd_data_g;

  dual_clock_fifo #(.DW(DW), .AW(AW), .MODE(dcfifo_pkg::PTR_BINARY)) i_dual_clock_fifo (
    .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .wr_full(wr_full), .rd_clk(rd_clk), .rd_rst_n(rd_rst_n), .rd_en(rd_en),
    .rd_data(rd_data), .rd_empty(rd_empty)
  );

  dual_clock_fifo #(.DW(DW), .AW(AW), .MODE(dcfifo_pkg::PTR_GRAY)) i_dual_clock_fifo_g (
    .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .wr_full(wr_full_g), .rd_clk(rd_clk), .rd_rst_n(rd_rst_n), .rd_en(rd_en),
    .rd_data(rd_data_g), .rd_empty(rd_empty_g)
  );

  int            n_chk = 0;
  int            n_bad = 0;
  bit            done  = 1'b0;
  logic [DW-1:0] ref_q [$];

  // each entry: word count [31:16], write gap [15:8], read gap [7:1], expected final empty [0]
  localparam logic [31:0] VEC [6] = '{
    {16'd40,  8'd0, 7'd0, 1'b1},
    {16'd40,  8'd0, 7'd3, 1'b1},
    {16'd40,  8'd3, 7'd0, 1'b1},
    {16'd64,  8'd1, 7'd1, 1'b1},
    {16'd25,  8'd0, 7'd5, 1'b1},
    {16'd100, 8'd2, 7'd0, 1'b1}
  };

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  task automatic write_stream(input int n, input int gap, input logic [DW-1:0] base);
    int sent = 0;
    int idle = 0;
    while (sent < n) begin
      @(negedge wr_clk);
      wr_en = 1'b0;
      if (idle > 0) idle--;
      else if (!wr_full) begin
        wr_en   = 1'b1;
        wr_data = base + DW'(sent);
        ref_q.push_back(wr_data);
        sent++;
        idle = gap;
      end
    end
    @(negedge wr_clk);
    wr_en = 1'b0;
  endtask

  task automatic read_stream(input int n, input int gap);
    int            got  = 0;
    int            idle = 0;
    bit            pend = 1'b0;
    logic [DW-1:0] exp  = '0;
    while (got < n || pend) begin
      @(negedge rd_clk);
      if (pend) begin
        chk(rd_data == exp, "R2 word order", 32'(rd_data), 32'(exp));
        chk(rd_data_g == rd_data, "R11 gray-indexed data", 32'(rd_data_g), 32'(rd_data));
        chk(rd_empty_g == rd_empty, "R11 gray-indexed empty", 32'(rd_empty_g), 32'(rd_empty));
        pend = 1'b0;
      end
      rd_en = 1'b0;
      if (idle > 0) idle--;
      else if (got < n && !rd_empty) begin
        if (ref_q.size() == 0) begin
          chk(1'b0, "R2 read with no reference word", 32'(rd_empty), 32'd1);
        end else begin
          exp = ref_q.pop_front();
        end
        rd_en = 1'b1;
        pend  = 1'b1;
        got++;
        idle = gap;
      end
    end
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog R2 actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] held;
    wr_rst_n = 1'b0;
    rd_rst_n = 1'b0;
    wr_en    = 1'b0;
    rd_en    = 1'b0;
    wr_data  = '0;
    repeat (5) @(negedge rd_clk);
    @(negedge wr_clk) wr_rst_n = 1'b1;
    @(negedge rd_clk) rd_rst_n = 1'b1;
    repeat (6) @(negedge rd_clk);

    // R1 reset values
    chk(rd_empty == 1'b1, "R1 empty after reset", 32'(rd_empty), 32'd1);
    chk(wr_full == 1'b0, "R1 full after reset", 32'(wr_full), 32'd0);
    chk(rd_data == '0, "R1 read data after reset", 32'(rd_data), 32'd0);
    chk(rd_empty_g == 1'b1 && wr_full_g == 1'b0, "R11 gray build reset flags",
        32'({wr_full_g, rd_empty_g}), 32'b01);

    // R3 fill with no reads
    for (int i = 0; i < DEPTH; i++) begin
      @(negedge wr_clk);
      if (i == DEPTH - 1) chk(wr_full == 1'b0, "R3 full before last slot", 32'(wr_full), 32'd0);
      wr_en   = 1'b1;
      wr_data = DW'(16'h1000 + i);
      ref_q.push_back(wr_data);
    end
    @(negedge wr_clk);
    chk(wr_full == 1'b1, "R3 full after DEPTH writes", 32'(wr_full), 32'd1);
    chk(wr_full_g == 1'b1, "R11 gray build full", 32'(wr_full_g), 32'd1);

    // R4 writes while full are dropped
    wr_data = 16'hDEAD;
    repeat (3) begin
      @(negedge wr_clk);
      chk(wr_full == 1'b1, "R4 full holds under blocked writes", 32'(wr_full), 32'd1);
    end
    wr_en = 1'b0;

    // R8 full clears after one read
    read_stream(1, 0);
    repeat (4) @(posedge wr_clk);
    @(negedge wr_clk);
    chk(wr_full == 1'b0, "R8 full clears after read", 32'(wr_full), 32'd0);

    // R4 stored words intact, R5 empty on last read
    read_stream(DEPTH - 1, 0);
    chk(rd_empty == 1'b1, "R5 empty right after last read", 32'(rd_empty), 32'd1);
    chk(rd_data == DW'(16'h1000 + DEPTH - 1), "R4 last word not overwritten",
        32'(rd_data), 32'(16'h1000 + DEPTH - 1));

    // R6 reads while empty are dropped
    held = rd_data;
    repeat (3) begin
      @(negedge rd_clk);
      rd_en = 1'b1;
    end
    @(negedge rd_clk);
    rd_en = 1'b0;
    chk(rd_data == held, "R6 read data unchanged under blocked reads", 32'(rd_data), 32'(held));
    chk(rd_empty == 1'b1, "R6 still empty", 32'(rd_empty), 32'd1);

    // R7 empty clears after one write
    write_stream(1, 0, 16'h0A5A);
    repeat (4) @(posedge rd_clk);
    @(negedge rd_clk);
    chk(rd_empty == 1'b0, "R7 empty clears after write", 32'(rd_empty), 32'd0);
    read_stream(1, 0);
    chk(rd_data == 16'h0A5A, "R6 read pointer did not move", 32'(rd_data), 32'h0A5A);

    // R9 output holds with no read
    repeat (5) @(negedge rd_clk);
    chk(rd_data == 16'h0A5A, "R9 read data holds when idle", 32'(rd_data), 32'h0A5A);

    // R2 rate patterns from the table
    for (int v = 0; v < 6; v++) begin
      fork
        write_stream(int'(VEC[v][31:16]), int'(VEC[v][15:8]), DW'(v * 256));
        read_stream(int'(VEC[v][31:16]), int'(VEC[v][7:1]));
      join
      repeat (4) @(negedge rd_clk);
      chk(rd_empty == VEC[v][0], "R2 empty after pattern", 32'(rd_empty), 32'(VEC[v][0]));
      chk(wr_full == 1'b0, "R8 full clear after pattern", 32'(wr_full), 32'd0);
      chk(ref_q.size() == 0, "R2 all words delivered", 32'(ref_q.size()), 32'd0);
    end

    done = 1'b1;
    summary();
    $finish;
  end
endmodule